// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Sleep and Hardware Wakeup

This block receives asynchronous serial characters of 8 data bits and one stop bit, least significant bit first. The line is sampled on every tick of a 16x baud strobe. Three samples from the middle of each bit are combined by majority vote, and any disagreement among them is recorded as noise. Bits are assembled in a shift register. Each finished character is then copied into a separate holding register, so the next character can be received while the previous one is still waiting to be read.

On a shared link, a receiver that does not care about the current message can be put to sleep. While it sleeps, no receive status flag can become set. Hardware ends the sleep at the start of the next message. A method bit selects how that start is detected. In line-idle mode, a full character time of continuous marking on the line wakes the receiver. In address-mark mode, a character whose top data bit is 1 wakes the receiver, and that character is delivered to software as the address.

Top module: `uart_mp_rx`

## Requirements
- R1: After reset, all status flags, the sleep bit, the method bit and the data output are 0.
- R2: A frame consists of a start bit of 0, then 8 data bits with the LSB first, then a stop bit. Each bit lasts 16 ticks, and its value is the majority of the samples taken on ticks 7, 8 and 9 of the bit. When the frame is accepted and the holding register is empty, the character appears on `rx_data_o` and `rdf_o` goes to 1.
- R3: `noise_o` of a loaded character is 1 when the three samples of any bit in the frame, start bit included, did not all agree.
- R4: `ferr_o` of a loaded character is 1 when its stop bit voted 0.
- R5: When a character completes while `rdf_o` is 1, `ovr_o` goes to 1, and the held data, noise flag and framing flag stay unchanged.
- R6: A pulse on `rd_i` clears `rdf_o`, `ovr_o` and `idle_o`.
- R7: `idle_o` goes to 1 after 160 consecutive ticks of the line at 1, but only if a character has completed since the previous idle detection. It is set once for each idle period.
- R8: Writing `cfg_sleep_i`=1 through `cfg_we_i` puts the receiver to sleep. While it sleeps, `rdf_o`, `ovr_o`, `idle_o`, `noise_o` and `ferr_o` cannot become set, and characters are discarded.
- R9: With `cfg_addr_mode_i`=0 written, detection of an idle line clears the sleep bit, and no idle flag is raised for that detection.
- R10: With `cfg_addr_mode_i`=1 written, a character received during sleep with bit 7 at 1 clears the sleep bit and is loaded under the rules of R2 to R5. A character with bit 7 at 0 is discarded.
- R11: Writing `cfg_sleep_i`=0 through `cfg_we_i` clears the sleep bit.
- R12: A start bit whose vote is 1 (a false start) produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, asynchronous |
| os_tick_i | input | 1 | Oversampling strobe, 16 per bit |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_sleep_i | input | 1 | Sleep bit value to write |
| cfg_addr_mode_i | input | 1 | Wake method to write: 1 address-mark, 0 idle-line |
| rd_i | input | 1 | Data-read strobe |
| rx_data_o | output | 8 | Holding register |
| rdf_o | output | 1 | Receive data full |
| ovr_o | output | 1 | Overrun |
| idle_o | output | 1 | Idle line detected |
| noise_o | output | 1 | Noise in held character |
| ferr_o | output | 1 | Framing error in held character |
| sleep_o | output | 1 | Sleep bit |
| addr_mode_o | output | 1 | Wake method bit |

## Verification
The assertions assume three things about the inputs: `rd_i` and a completed character do not coincide in a way that hides a flag edge, `os_tick_i` is a clean one-cycle-per-sample strobe, and the line settles between bit boundaries. The stimulus ties the tick high and changes `rxd_i` only on falling clock edges, holding each bit for 16 cycles. Noise is injected as a single-cycle glitch at tick 8 of a bit, so that it always falls inside the vote window without flipping the vote. Idle periods are kept well clear of the 160-tick boundary: stretches of marking are either short, or long enough that detection is certain.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              noise;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     rx_i,
  output logic     done_o,
  output rx_char_t chr_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned IW  = $clog2(DATA_W + 1);
  localparam int unsigned MID = OVS / 2;

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              s0_q, s0_d, s1_q, s1_d, bitv_q, bitv_d, nacc_q, nacc_d;
  logic              done_q, done_d;
  rx_char_t          chr_q, chr_d;
  logic              vote, disagree;

  always_comb begin
    vote     = (s0_q & s1_q) | (s0_q & rx_i) | (s1_q & rx_i);
    disagree = !((s0_q == s1_q) && (s1_q == rx_i));
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    s0_d    = s0_q;
    s1_d    = s1_q;
    bitv_d  = bitv_q;
    nacc_d  = nacc_q;
    done_d  = 1'b0;
    chr_d   = chr_q;
    if (tick_i) begin
      if (state_q == ST_IDLE) begin
        if (!rx_i) begin
          state_d = ST_START;
          cnt_d   = CW'(1);
          nacc_d  = 1'b0;
        end
      end else begin
        cnt_d = (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + CW'(1);
        if (cnt_q == CW'(MID - 1)) s0_d = rx_i;
        if (cnt_q == CW'(MID))     s1_d = rx_i;
        if (cnt_q == CW'(MID + 1)) begin
          bitv_d = vote;
          if (disagree) nacc_d = 1'b1;
          if (state_q == ST_STOP) begin
            done_d     = 1'b1;
            chr_d.data = sh_q;
            chr_d.noise = nacc_q | disagree;
            chr_d.ferr = !vote;
            state_d    = ST_IDLE;
          end
        end
        if (cnt_q == CW'(OVS - 1)) begin
          if (state_q == ST_START) begin
            if (bitv_q) state_d = ST_IDLE;
            else begin
              state_d = ST_DATA;
              idx_d   = '0;
            end
          end else if (state_q == ST_DATA) begin
            sh_d  = {bitv_q, sh_q[DATA_W-1:1]};
            idx_d = idx_q + IW'(1);
            if (idx_q == IW'(DATA_W - 1)) state_d = ST_STOP;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      s0_q    <= 1'b1;
      s1_q    <= 1'b1;
      bitv_q  <= 1'b1;
      nacc_q  <= 1'b0;
      done_q  <= 1'b0;
      chr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      s0_q    <= s0_d;
      s1_q    <= s1_d;
      bitv_q  <= bitv_d;
      nacc_q  <= nacc_d;
      done_q  <= done_d;
      chr_q   <= chr_d;
    end
  end

  assign done_o = done_q;
  assign chr_o  = chr_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(DATA_W)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick_i && cnt_q == CW'(OVS - 1) && bitv_q) |=> state_q == ST_IDLE); // R12
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int unsigned TICKS = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  output logic idle_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (tick_i) begin
      if (!rx_i) cnt_d = '0;
      else if (cnt_q != CW'(TICKS)) begin
        cnt_d   = cnt_q + CW'(1);
        pulse_d = (cnt_q == CW'(TICKS - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign idle_o = pulse_q;

  AST_IDLE_AT_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> cnt_q == CW'(TICKS)); // R7
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned IDLE_BITS = 10,
  parameter int unsigned SYNC_FF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sleep_i,
  input  logic              cfg_addr_mode_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rdf_o,
  output logic              ovr_o,
  output logic              idle_o,
  output logic              noise_o,
  output logic              ferr_o,
  output logic              sleep_o,
  output logic              addr_mode_o
);
  localparam int unsigned IDLE_TICKS = OVS * IDLE_BITS;

  logic     rx_s, done, idle_p;
  rx_char_t chr;

  uart_rx_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rx_s));

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick_i(os_tick_i), .rx_i(rx_s),
    .done_o(done), .chr_o(chr));

  uart_rx_idle #(.TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick_i(os_tick_i), .rx_i(rx_s), .idle_o(idle_p));

  logic [DATA_W-1:0] data_q, data_d;
  logic sleep_q, sleep_d, mode_q, mode_d, rdf_q, rdf_d, ovr_q, ovr_d;
  logic idle_q, idle_d, noise_q, noise_d, ferr_q, ferr_d, seen_q, seen_d;
  logic wake_addr, wake_idle, accept, rdf_eff, load;

  always_comb begin
    wake_addr = sleep_q & mode_q & done & chr.data[DATA_W-1];
    wake_idle = sleep_q & !mode_q & idle_p;
    accept    = done & (!sleep_q | wake_addr);
    rdf_eff   = rdf_q & !rd_i;
    load      = accept & !rdf_eff;

    sleep_d = sleep_q;
    mode_d  = mode_q;
    if (cfg_we_i) begin
      sleep_d = cfg_sleep_i;
      mode_d  = cfg_addr_mode_i;
    end else if (wake_addr | wake_idle) begin
      sleep_d = 1'b0;
    end

    rdf_d  = rdf_eff | load;
    ovr_d  = (ovr_q & !rd_i) | (accept & rdf_eff);
    idle_d = (idle_q & !rd_i) | (idle_p & !sleep_q & seen_q);
    seen_d = idle_p ? 1'b0 : (done ? 1'b1 : seen_q);

    data_d  = data_q;
    noise_d = noise_q;
    ferr_d  = ferr_q;
    if (load) begin
      data_d  = chr.data;
      noise_d = chr.noise;
      ferr_d  = chr.ferr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      sleep_q <= 1'b0;
      mode_q  <= 1'b0;
      rdf_q   <= 1'b0;
      ovr_q   <= 1'b0;
      idle_q  <= 1'b0;
      noise_q <= 1'b0;
      ferr_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      sleep_q <= sleep_d;
      mode_q  <= mode_d;
      rdf_q   <= rdf_d;
      ovr_q   <= ovr_d;
      idle_q  <= idle_d;
      noise_q <= noise_d;
      ferr_q  <= ferr_d;
      seen_q  <= seen_d;
    end
  end

  assign rx_data_o   = data_q;
  assign rdf_o       = rdf_q;
  assign ovr_o       = ovr_q;
  assign idle_o      = idle_q;
  assign noise_o     = noise_q;
  assign ferr_o      = ferr_q;
  assign sleep_o     = sleep_q;
  assign addr_mode_o = mode_q;

  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $stable(data_q) && $stable(noise_q) && $stable(ferr_q)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done && !cfg_we_i) |=> !rdf_q && !ovr_q); // R6
  AST_SLEEP_NO_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |=> !$rose(idle_q)); // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !(done && mode_q && chr.data[DATA_W-1])) |=> !$rose(rdf_q) && !$rose(ovr_q)); // R8
  AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && mode_q && done && chr.data[DATA_W-1] && !cfg_we_i) |=> !sleep_q); // R10
endmodule

// File: tb/uart_mp_rx_tb_top.sv
`timescale 1ns/1ps
module uart_mp_rx_tb_top;
  logic clk, rst_n, rxd, tick, we, wsleep, wmode, rd;
  logic [7:0] data;
  logic rdf, ovr, idle, noise, ferr, sleep, mode;

  uart_mp_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .os_tick_i(tick),
    .cfg_we_i(we), .cfg_sleep_i(wsleep), .cfg_addr_mode_i(wmode), .rd_i(rd),
    .rx_data_o(data), .rdf_o(rdf), .ovr_o(ovr), .idle_o(idle),
    .noise_o(noise), .ferr_o(ferr), .sleep_o(sleep), .addr_mode_o(mode));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int hi = 0;
  logic [7:0] e_data;
  bit e_rdf, e_ovr, e_idle, e_noise, e_ferr, e_sleep, e_mode, e_seen;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string ctx, string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s %s: actual=%0h expected=%0h", ctx, req, what, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk(ctx, "R2", "data", data, e_data);
    chk(ctx, "R2", "rdf", rdf, e_rdf);
    chk(ctx, "R3", "noise", noise, e_noise);
    chk(ctx, "R4", "ferr", ferr, e_ferr);
    chk(ctx, "R5", "ovr", ovr, e_ovr);
    chk(ctx, "R7", "idle", idle, e_idle);
    chk(ctx, "R8", "sleep", sleep, e_sleep);
    chk(ctx, "R11", "mode", mode, e_mode);
  endtask

  function automatic void model_char(logic [7:0] d, bit n, bit f);
    bit acc;
    e_seen = 1;
    acc = !e_sleep;
    if (e_sleep && e_mode && d[7]) begin
      e_sleep = 0;
      acc = 1;
    end
    if (acc) begin
      if (e_rdf) e_ovr = 1;
      else begin
        e_data = d; e_rdf = 1; e_noise = n; e_ferr = f;
      end
    end
  endfunction

  // glitch: bit index 0..9 (0 = start) gets a one-cycle flip at tick 8; -1 none
  task automatic send(logic [7:0] d, int glitch, bit stop_v, string ctx);
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
      for (int t = 0; t < 16; t++) begin
        rxd = (b == glitch && t == 8) ? ~v : v;
        cyc(1);
      end
    end
    rxd = 1'b1;
    cyc(24);
    hi = stop_v ? 40 : 24;
    model_char(d, glitch >= 0, !stop_v);
    check_all(ctx);
  endtask

  task automatic do_read(string ctx);
    rd = 1'b1; cyc(1); rd = 1'b0; cyc(1);
    hi += 2;
    e_rdf = 0; e_ovr = 0; e_idle = 0;
    check_all(ctx);
  endtask

  task automatic do_write(bit s, bit m, string ctx);
    wsleep = s; wmode = m; we = 1'b1; cyc(1); we = 1'b0; cyc(1);
    hi += 2;
    e_sleep = s; e_mode = m;
    check_all(ctx);
  endtask

  task automatic idle_gap(string ctx);
    if (hi < 160) begin
      cyc(200 - hi);
      hi = 200;
      if (e_sleep) begin
        if (!e_mode) e_sleep = 0;
      end else if (e_seen) e_idle = 1;
      e_seen = 0;
    end else begin
      cyc(10);
    end
    check_all(ctx);
  endtask

  task automatic false_start(string ctx);
    rxd = 1'b0; cyc(2); rxd = 1'b1; cyc(30);
    hi = 30;
    check_all(ctx);
  endtask

  task automatic guard();
    if (hi > 100) idle_gap("pre-idle R7");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; rxd = 1; tick = 1; we = 0; wsleep = 0; wmode = 0; rd = 0;
    e_data = 0; e_rdf = 0; e_ovr = 0; e_idle = 0; e_noise = 0; e_ferr = 0;
    e_sleep = 0; e_mode = 0; e_seen = 0;
    cyc(3);
    check_all("reset R1");
    rst_n = 1;
    cyc(2); hi = 2;
    send(8'hA5, -1, 1, "clean R2");
    send(8'h3C, 3, 1, "overrun R5");
    do_read("read R6");
    send(8'h5A, 4, 1, "data glitch R3");
    do_read("read R6");
    send(8'h81, 0, 1, "start glitch R3");
    do_read("read R6");
    send(8'hF0, -1, 0, "stop low R4");
    do_read("read R6");
    false_start("false start R12");
    idle_gap("idle once R7");
    idle_gap("idle again R7");
    do_read("read clears idle R6");
    do_write(1, 0, "sleep idle mode R8");
    send(8'h99, 2, 0, "discard asleep R8");
    idle_gap("idle wake R9");
    do_write(1, 1, "sleep addr mode R8");
    send(8'h12, -1, 1, "non-address R10");
    send(8'h85, -1, 1, "address wake R10");
    do_read("read R6");
    do_write(1, 1, "sleep R8");
    do_write(0, 1, "software clear R11");
    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom_range(0, 5);
      guard();
      case (op)
        0, 1: begin
          int g;
          g = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 9) : -1;
          send(8'($urandom), g, $urandom_range(0, 7) != 0, "random char R2");
        end
        2: do_read("random read R6");
        3: idle_gap("random idle R7");
        4: do_write($urandom_range(0, 1), $urandom_range(0, 1), "random write R11");
        default: false_start("random false start R12");
      endcase
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule